// File: doc/BRIEF.md
# Draw-Completion Token and Finish Interrupt Controller

This block lets a graphics pipeline report its progress to a host CPU. The pipeline posts one of two kinds of event. A token post carries a 16-bit marker value and an optional interrupt request. A finish post marks the end of a frame's drawing. Every post also carries a cycle delay. The event does not become visible until that delay has run out. At that point the controller copies the held marker into the visible token register and sets the matching status flags.

The CPU works through two 16-bit registers on a simple byte-addressed bus. A control register holds two interrupt enables and two write-1-to-clear status flags. A read-only token register shows the last marker that became visible. Each interrupt line is the AND of its status flag and its enable. Both interrupt lines are registered outputs.

A single down-counter times the delay. A post that arrives while an event is still waiting replaces the held marker, merges its request flags with those already held and restarts the counter with its own delay.

Top module: `gsync_ctrl`

## Requirements
- R1: After reset, both interrupt outputs are 0 and reads of the control register (offset 0x0A) and of the token register (offset 0x0E) both return 0.
- R2: A bus write to offset 0x0A loads control bit 0 (token interrupt enable) and bit 1 (finish interrupt enable) from the write data. A read of 0x0A returns the enables in bits 1:0, the token status in bit 2, the finish status in bit 3, and 0 in bits 15:4. Read data appears one cycle after the address is presented.
- R3: Take a token post that requests an interrupt and is sampled with delay D at clock edge E. The token status (bit 2) becomes 1 at edge E+D+1 and not earlier.
- R4: A posted token value is held apart from the visible token. A read of 0x0E keeps returning the previous value until the delayed event fires, and returns the posted value after that.
- R5: Writing 1 to control bit 2 or bit 3 clears that status flag. Writing 0 to either bit leaves the flag unchanged. If an event sets a flag in the same cycle that a write clears it, the set wins.
- R6: irq_token equals token status AND token enable. irq_finish equals finish status AND finish enable. Both update at the same edge as the state they follow.
- R7: A finish post sampled with delay D at edge E sets the finish status (bit 3) at edge E+D+1.
- R8: A post with delay 0 takes effect on the clock edge that follows the edge at which it is sampled.
- R9: A token post without an interrupt request updates the visible token but does not set the token status.
- R10: A post that arrives while an event is outstanding replaces the held token value, ORs its request flags into those held, and restarts the delay with its own value. The earlier post's timing is dropped.
- R11: Writes to the token register offset have no effect. Reads of any offset other than 0x0A and 0x0E return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_token | input | 1 | Pipeline posts a token this cycle |
| post_token_value | input | 16 | Token marker value |
| post_token_irq | input | 1 | Token post requests an interrupt |
| post_finish | input | 1 | Pipeline posts a finish event this cycle |
| post_delay | input | DLY_W | Cycle delay before the post takes effect |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data for bus_addr |
| irq_token | output | 1 | Token interrupt request |
| irq_finish | output | 1 | Finish interrupt request |

## Verification
The bench counts edges against the delay. A design that fires one cycle early or late, or that shows a held token before it fires, fails the timing checks and the token read-back. A second post is issued while the first is still waiting and with a longer delay than the first had left. A design that kept the first countdown would raise the interrupt too soon, and one that dropped the earlier interrupt request would never raise it. The enable, status and clear checks cover a flag set while its interrupt is disabled, a zero written to a status bit, and writes aimed at the read-only token register. A design with write-1 semantics reversed or with ungated interrupts gives a wrong line level or a wrong control readback.

// File: rtl/gsync_pkg.sv
package gsync_pkg;
  localparam int DATA_W = 16;

  localparam logic [7:0] OFS_CTRL  = 8'h0A;
  localparam logic [7:0] OFS_TOKEN = 8'h0E;

  localparam int CB_EN_TOK = 0;
  localparam int CB_EN_FIN = 1;
  localparam int CB_ST_TOK = 2;
  localparam int CB_ST_FIN = 3;

  typedef struct packed {
    logic upd;      // held token must be copied to visible token
    logic tok_req;  // token interrupt requested
    logic fin_req;  // finish event requested
  } evt_flags_t;
endpackage

// File: rtl/gsync_delay_timer.sv
module gsync_delay_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);
  logic             active;
  logic [DLY_W-1:0] cnt;

  // a new load always takes precedence and restarts the countdown
  assign fire = active && (cnt == '0) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= dly;
    end else if (fire) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - DLY_W'(1);
    end
  end
endmodule

// File: rtl/gsync_event_hold.sv
module gsync_event_hold
  import gsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_post,
  input  logic [DATA_W-1:0] tok_val,
  input  logic              tok_irq,
  input  logic              fin_post,
  input  logic              fire,
  output logic [DATA_W-1:0] pend_token,
  output evt_flags_t        flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_token <= '0;
      flags      <= '0;
    end else if (tok_post || fin_post) begin
      if (tok_post) pend_token <= tok_val;
      flags.upd     <= flags.upd     | tok_post;
      flags.tok_req <= flags.tok_req | (tok_post & tok_irq);
      flags.fin_req <= flags.fin_req | fin_post;
    end else if (fire) begin
      flags <= '0;
    end
  end
endmodule

// File: rtl/gsync_ctrl_regs.sv
module gsync_ctrl_regs
  import gsync_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              fire,
  input  logic [DATA_W-1:0] pend_token,
  input  evt_flags_t        flags,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_token,
  output logic              irq_finish,
  output logic              en_tok,
  output logic              en_fin,
  output logic              st_tok,
  output logic              st_fin,
  output logic [DATA_W-1:0] vis_token
);
  logic              ctrl_wr;
  logic              en_tok_n, en_fin_n, st_tok_n, st_fin_n;
  logic [DATA_W-1:0] rd_n;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

  always_comb begin
    en_tok_n = ctrl_wr ? bus_wdata[CB_EN_TOK] : en_tok;
    en_fin_n = ctrl_wr ? bus_wdata[CB_EN_FIN] : en_fin;
    st_tok_n = st_tok;
    st_fin_n = st_fin;
    if (ctrl_wr && bus_wdata[CB_ST_TOK]) st_tok_n = 1'b0;
    if (ctrl_wr && bus_wdata[CB_ST_FIN]) st_fin_n = 1'b0;
    if (fire && flags.tok_req) st_tok_n = 1'b1;
    if (fire && flags.fin_req) st_fin_n = 1'b1;
  end

  always_comb begin
    rd_n = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      rd_n[CB_EN_TOK] = en_tok;
      rd_n[CB_EN_FIN] = en_fin;
      rd_n[CB_ST_TOK] = st_tok;
      rd_n[CB_ST_FIN] = st_fin;
    end else if (bus_addr == ADDR_W'(OFS_TOKEN)) begin
      rd_n = vis_token;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_tok     <= 1'b0;
      en_fin     <= 1'b0;
      st_tok     <= 1'b0;
      st_fin     <= 1'b0;
      irq_token  <= 1'b0;
      irq_finish <= 1'b0;
      vis_token  <= '0;
      bus_rdata  <= '0;
    end else begin
      en_tok     <= en_tok_n;
      en_fin     <= en_fin_n;
      st_tok     <= st_tok_n;
      st_fin     <= st_fin_n;
      irq_token  <= st_tok_n & en_tok_n;
      irq_finish <= st_fin_n & en_fin_n;
      bus_rdata  <= rd_n;
      if (fire && flags.upd) vis_token <= pend_token;
    end
  end
endmodule

// File: rtl/gsync_ctrl.sv
module gsync_ctrl
  import gsync_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post_token,
  input  logic [15:0]       post_token_value,
  input  logic              post_token_irq,
  input  logic              post_finish,
  input  logic [DLY_W-1:0]  post_delay,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq_token,
  output logic              irq_finish
);
  logic              post_any;
  logic              tmr_fire;
  logic [DATA_W-1:0] pend_token;
  evt_flags_t        held_flags;
  logic              en_tok, en_fin, st_tok, st_fin;
  logic [DATA_W-1:0] vis_token;

  assign post_any = post_token || post_finish;

  gsync_delay_timer #(.DLY_W(DLY_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (post_any),
    .dly  (post_delay),
    .fire (tmr_fire)
  );

  gsync_event_hold u_hold (
    .clk        (clk),
    .rst        (rst),
    .tok_post   (post_token),
    .tok_val    (post_token_value),
    .tok_irq    (post_token_irq),
    .fin_post   (post_finish),
    .fire       (tmr_fire),
    .pend_token (pend_token),
    .flags      (held_flags)
  );

  gsync_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .fire       (tmr_fire),
    .pend_token (pend_token),
    .flags      (held_flags),
    .bus_rdata  (bus_rdata),
    .irq_token  (irq_token),
    .irq_finish (irq_finish),
    .en_tok     (en_tok),
    .en_fin     (en_fin),
    .st_tok     (st_tok),
    .st_fin     (st_fin),
    .vis_token  (vis_token)
  );
endmodule

// File: rtl/gsync_ctrl_checker.sv
module gsync_ctrl_checker
  import gsync_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DLY_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              post_any,
  input logic [DLY_W-1:0]  post_delay,
  input logic              fire,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              st_tok,
  input logic              en_tok,
  input logic              en_fin,
  input logic              irq_token,
  input logic              irq_finish,
  input logic [15:0]       vis_token
);
  // R6: an interrupt line is never high without its enable
  a_r6_tok_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_token |-> en_tok);
  a_r6_fin_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_finish |-> en_fin);

  // R5: a write-1 clear with no concurrent event drops the token status
  a_r5_tok_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[CB_ST_TOK] && !fire)
    |=> !st_tok);

  // R3: token status only rises when the delayed event fires
  a_r3_status_from_fire: assert property (@(posedge clk) disable iff (rst)
    $rose(st_tok) |-> $past(fire));

  // R4: visible token only moves when the delayed event fires
  a_r4_token_on_fire: assert property (@(posedge clk) disable iff (rst)
    !$stable(vis_token) |-> $past(fire));

  // R8: a zero-delay post fires on the following edge unless re-posted
  a_r8_zero_delay: assert property (@(posedge clk) disable iff (rst)
    (post_any && post_delay == '0) |=> (fire || post_any));
endmodule

bind gsync_ctrl gsync_ctrl_checker #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .post_any   (post_any),
  .post_delay (post_delay),
  .fire       (tmr_fire),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .st_tok     (st_tok),
  .en_tok     (en_tok),
  .en_fin     (en_fin),
  .irq_token  (irq_token),
  .irq_finish (irq_finish),
  .vis_token  (vis_token)
);

// File: tb/gsync_ctrl_test.sv
module gsync_ctrl_test;
  localparam int ADDR_W = 8;
  localparam int DLY_W  = 16;
  localparam logic [7:0] A_CTRL = 8'h0A;
  localparam logic [7:0] A_TOK  = 8'h0E;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              post_token = 1'b0;
  logic [15:0]       post_token_value = '0;
  logic              post_token_irq = 1'b0;
  logic              post_finish = 1'b0;
  logic [DLY_W-1:0]  post_delay = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [15:0]       bus_wdata = '0;
  logic [15:0]       bus_rdata;
  logic              irq_token, irq_finish;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  gsync_ctrl #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // returns at the falling edge after the sampling edge
  task automatic post(input logic tok, input logic [15:0] v, input logic irq,
                      input logic fin, input int dly);
    @(negedge clk);
    post_token = tok; post_token_value = v; post_token_irq = irq;
    post_finish = fin; post_delay = DLY_W'(dly);
    @(negedge clk);
    post_token = 1'b0; post_finish = 1'b0; post_token_irq = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq_token", irq_token, 0);
    chk("R1 irq_finish", irq_finish, 0);
    bus_read(A_CTRL, d); chk("R1 ctrl", d, 0);
    bus_read(A_TOK, d);  chk("R1 token", d, 0);
  endtask

  task automatic t_enables();
    logic [15:0] d;
    bus_write(A_CTRL, 16'hFFF3);
    bus_read(A_CTRL, d); chk("R2 enables readback", d, 16'h0003);
    bus_write(A_CTRL, 16'h0000);
    bus_read(A_CTRL, d); chk("R2 enables cleared", d, 16'h0000);
  endtask

  task automatic t_token_irq();
    logic [15:0] d;
    bus_write(A_CTRL, 16'h0001);
    post(1, 16'hBEEF, 1, 0, 5);
    wait_n(5); chk("R3 irq not before delay", irq_token, 0);
    wait_n(1); chk("R3 irq at delay+1", irq_token, 1);
    bus_read(A_TOK, d);  chk("R4 token visible after fire", d, 16'hBEEF);
    bus_read(A_CTRL, d); chk("R3 token status", d, 16'h0005);
    bus_write(A_CTRL, 16'h0001);
    bus_read(A_CTRL, d); chk("R5 write 0 keeps status", d, 16'h0005);
    bus_write(A_CTRL, 16'h0005);
    chk("R5 irq after clear", irq_token, 0);
    bus_read(A_CTRL, d); chk("R5 write 1 clears status", d, 16'h0001);
  endtask

  task automatic t_pending();
    logic [15:0] d;
    post(1, 16'h1234, 0, 0, 20);
    bus_read(A_TOK, d); chk("R4 held token not visible", d, 16'hBEEF);
    wait_n(25);
    bus_read(A_TOK, d);  chk("R9 token updated without irq", d, 16'h1234);
    bus_read(A_CTRL, d); chk("R9 no token status", d, 16'h0001);
    chk("R9 irq stays low", irq_token, 0);
  endtask

  task automatic t_finish_gate();
    logic [15:0] d;
    bus_write(A_CTRL, 16'h0000);
    post(0, 16'h0, 0, 1, 3);
    wait_n(3); chk("R7 finish not before delay", irq_finish, 0);
    wait_n(1); chk("R6 finish irq masked", irq_finish, 0);
    bus_read(A_CTRL, d); chk("R7 finish status", d, 16'h0008);
    bus_write(A_CTRL, 16'h0002);
    chk("R6 finish irq on enable", irq_finish, 1);
    bus_write(A_CTRL, 16'h000A);
    chk("R5 finish irq after clear", irq_finish, 0);
    bus_read(A_CTRL, d); chk("R5 finish status cleared", d, 16'h0002);
  endtask

  task automatic t_zero_delay();
    logic [15:0] d;
    bus_write(A_CTRL, 16'h0001);
    post(1, 16'h00AA, 1, 0, 0);
    wait_n(1); chk("R8 zero delay fires next edge", irq_token, 1);
    bus_read(A_TOK, d); chk("R8 zero delay token", d, 16'h00AA);
    bus_write(A_CTRL, 16'h0005);
  endtask

  task automatic t_repost();
    logic [15:0] d;
    post(1, 16'h1111, 1, 0, 4);
    wait_n(1);
    post(1, 16'h2222, 0, 0, 6);
    wait_n(6); chk("R10 restarted delay", irq_token, 0);
    wait_n(1); chk("R10 merged irq request", irq_token, 1);
    bus_read(A_TOK, d); chk("R10 replaced token", d, 16'h2222);
    bus_write(A_CTRL, 16'h0005);
  endtask

  task automatic t_ignored();
    logic [15:0] d;
    bus_write(A_TOK, 16'hFFFF);
    bus_read(A_TOK, d);  chk("R11 token write ignored", d, 16'h2222);
    bus_read(8'h00, d);  chk("R11 unmapped read zero", d, 16'h0000);
    bus_read(8'h0C, d);  chk("R11 unmapped read zero 0C", d, 16'h0000);
    bus_read(A_CTRL, d); chk("R11 ctrl untouched", d, 16'h0001);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_enables();
    t_token_irq();
    t_pending();
    t_finish_gate();
    t_zero_delay();
    t_repost();
    t_ignored();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule